// File: doc/BRIEF.md
# Predicate Gate for a Wide-Issue Execute Packet

This block sits beside the dispatch stage of a wide-issue core and decides, for each of the eight instruction slots of an execute packet, whether the instruction in that slot is carried out or squashed. Each slot carries a valid flag and a small predicate field. The field is a 3-bit code that names one of five condition registers, plus an invert flag. The block looks up the named register and raises that slot's enable only when the predicate holds. A squashed instruction must have no architectural effect, and downstream units gate their writes with this enable.

The block keeps its own shadow of the five condition registers. Compare operations deliver their results through a single write-back port. Only whether the written value is zero matters, so each register is held as one bit. Slot enables are purely combinational from the slot inputs and the stored bits. A write-back updates the stored bit at the clock edge, so instructions issued in the following cycle see it.

The block holds no sequencing state. Apart from the five condition-register flops with asynchronous active-low reset, it has no states or transitions.

Top module: `pred_enable_unit`

Predicate codes (3 bits): 000 = none (unconditional), 001 = B0, 010 = B1, 011 = B2, 100 = A1, 101 = A2, 110 and 111 = reserved.

## Requirements
- R1: While reset is asserted, and after it is released until a write-back occurs, all five condition registers read as false. A slot predicated on a register (invert 0) is squashed, and one predicated on its inverse (invert 1) is enabled.
- R2: A valid slot with code 000 and invert 0 is always enabled, whatever the condition registers hold.
- R3: A slot whose valid input is low always has its enable low.
- R4: For codes 001 to 101, a valid slot's enable equals the stored bit of the named register (001=B0, 010=B1, 011=B2, 100=A1, 101=A2) XOR the invert flag.
- R5: A valid slot is squashed (enable low) when its code is 110 or 111 with either invert value, or when its code is 000 with invert 1.
- R6: A write-back with a register code 001 to 101 sets that register true if the 32-bit data is nonzero and false if it is zero. Slots see the new value from the cycle after the write.
- R7: A write-back with code 000, 110 or 111 changes no condition register.
- R8: Two slots in the same packet that name the same register, one with invert 0 and one with invert 1, give exactly one enabled slot.
- R9: Slot enables respond in the same cycle as the slot inputs, with no register stage.
- R10: A slot that reads a register in the same cycle as a write-back to it sees the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_valid | input | 1 | Compare write-back strobe |
| wb_code | input | 3 | Condition register targeted by the write-back |
| wb_data | input | 32 | Compare result value; nonzero means true |
| slot_valid | input | 8 | Per-slot instruction present |
| slot_code | input | 24 | Per-slot predicate code, slot i in bits [3i+2:3i] |
| slot_inv | input | 8 | Per-slot invert flag |
| slot_en | output | 8 | Per-slot execute enable |

## Verification
Slot enables are combinational, so each result is due in the same cycle its slot inputs are applied. A condition-register write-back shows up one clock edge later. The driver applies each packet just after a falling edge and queues its expected enable vector. The expected vector comes from a bench model of the register bits that still holds the pre-write values. The model is updated only after the vector is queued, which makes a write-back visible to the next packet and not the current one. The monitor pops and compares each vector a nanosecond after the same falling edge, after the inputs have settled and before the next rising edge commits any write.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int PRED_CODE_W = 3;
    localparam int NUM_COND    = 5;

    typedef enum logic [PRED_CODE_W-1:0] {
        PC_NONE = 3'd0,
        PC_B0   = 3'd1,
        PC_B1   = 3'd2,
        PC_B2   = 3'd3,
        PC_A1   = 3'd4,
        PC_A2   = 3'd5,
        PC_RSV6 = 3'd6,
        PC_RSV7 = 3'd7
    } pred_code_e;

    // Codes that name a real condition register
    function automatic logic code_is_reg(input logic [PRED_CODE_W-1:0] code);
        return (code >= 3'(PC_B0)) && (code <= 3'(PC_A2));
    endfunction

    // Bit index within the condition-register shadow
    function automatic int unsigned cond_index(input logic [PRED_CODE_W-1:0] code);
        return int'(code) - 1;
    endfunction

endpackage

// File: rtl/pred_cond_bank.sv
module pred_cond_bank
    import pred_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wb_valid,
    input  logic [PRED_CODE_W-1:0] wb_code,
    input  logic [DATA_W-1:0]      wb_data,
    output logic [NUM_COND-1:0]    cond_bits
);

    logic wb_truth;
    assign wb_truth = |wb_data;

    logic [NUM_COND-1:0] cond_q;

    for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
        localparam logic [PRED_CODE_W-1:0] MY_CODE = PRED_CODE_W'(g + 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cond_q[g] <= 1'b0;
            end else if (wb_valid && (wb_code == MY_CODE)) begin
                cond_q[g] <= wb_truth;
            end
        end
    end

    assign cond_bits = cond_q;

    // R6
    wb_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && code_is_reg(wb_code))
        |=> (cond_q[cond_index($past(wb_code))] == ($past(wb_data) != '0)));

    // R7
    wb_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !code_is_reg(wb_code)) |=> $stable(cond_q));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |=> $stable(cond_q));

endmodule

// File: rtl/pred_slot_eval.sv
module pred_slot_eval
    import pred_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid,
    input  logic [PRED_CODE_W-1:0] code,
    input  logic                   inv,
    input  logic [NUM_COND-1:0]    cond_bits,
    output logic                   en
);

    logic pass;

    always_comb begin
        pass = 1'b0;
        unique case (pred_code_e'(code))
            PC_NONE: pass = !inv;
            PC_B0, PC_B1, PC_B2, PC_A1, PC_A2:
                     pass = cond_bits[cond_index(code)] ^ inv;
            PC_RSV6, PC_RSV7:
                     pass = 1'b0;
        endcase
    end

    assign en = valid & pass;

    // R3
    no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !en);

    // R2
    uncond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && code == 3'(PC_NONE) && !inv) |-> en);

    // R5
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'(PC_RSV6) || code == 3'(PC_RSV7) || (code == 3'(PC_NONE) && inv)) |-> !en);

endmodule

// File: rtl/pred_enable_unit.sv
module pred_enable_unit
    import pred_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wb_valid,
    input  logic [PRED_CODE_W-1:0]           wb_code,
    input  logic [DATA_W-1:0]                wb_data,
    input  logic [NUM_SLOTS-1:0]             slot_valid,
    input  logic [NUM_SLOTS*PRED_CODE_W-1:0] slot_code,
    input  logic [NUM_SLOTS-1:0]             slot_inv,
    output logic [NUM_SLOTS-1:0]             slot_en
);

    logic [NUM_COND-1:0] cond_bits;

    pred_cond_bank #(.DATA_W(DATA_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_valid  (wb_valid),
        .wb_code   (wb_code),
        .wb_data   (wb_data),
        .cond_bits (cond_bits)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        pred_slot_eval i_eval (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid     (slot_valid[s]),
            .code      (slot_code[s*PRED_CODE_W +: PRED_CODE_W]),
            .inv       (slot_inv[s]),
            .cond_bits (cond_bits),
            .en        (slot_en[s])
        );
    end

    for (genvar p = 0; p + 1 < NUM_SLOTS; p++) begin : g_pair
        logic same_reg;
        assign same_reg = slot_valid[p] && slot_valid[p+1]
                       && code_is_reg(slot_code[p*PRED_CODE_W +: PRED_CODE_W])
                       && (slot_code[p*PRED_CODE_W +: PRED_CODE_W]
                           == slot_code[(p+1)*PRED_CODE_W +: PRED_CODE_W])
                       && (slot_inv[p] != slot_inv[p+1]);
        // R8
        pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            same_reg |-> (slot_en[p] ^ slot_en[p+1]));
    end

endmodule

// File: tb/test_pred_enable_unit.sv
`timescale 1ns/1ps
module test_pred_enable_unit;

    localparam int NS = 8;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wb_valid = 1'b0;
    logic [2:0]      wb_code = '0;
    logic [DW-1:0]   wb_data = '0;
    logic [NS-1:0]   slot_valid = '0;
    logic [NS*3-1:0] slot_code = '0;
    logic [NS-1:0]   slot_inv = '0;
    logic [NS-1:0]   slot_en;

    always #2 clk = ~clk;

    pred_enable_unit #(.NUM_SLOTS(NS), .DATA_W(DW)) i_pred_enable_unit (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_code(wb_code),
        .wb_data(wb_data), .slot_valid(slot_valid), .slot_code(slot_code),
        .slot_inv(slot_inv), .slot_en(slot_en)
    );

    typedef struct { logic [NS-1:0] exp; string req; } item_t;
    item_t sb_q[$];

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic mdl [5];

    logic [NS-1:0]   st_valid;
    logic [2:0]      st_code [NS];
    logic [NS-1:0]   st_inv;

    function automatic logic exp_slot(logic v, logic [2:0] c, logic n);
        if (!v) return 1'b0;
        if (c == 3'd0) return !n;
        if (c >= 3'd1 && c <= 3'd5) return mdl[int'(c) - 1] ^ n;
        return 1'b0;
    endfunction

    task automatic clear_stage();
        st_valid = '0;
        st_inv = '0;
        for (int i = 0; i < NS; i++) st_code[i] = 3'd0;
    endtask

    task automatic set_slot(int i, logic v, logic [2:0] c, logic n);
        st_valid[i] = v;
        st_code[i] = c;
        st_inv[i] = n;
    endtask

    // Drive one packet (and optional write-back), queue its expected enables
    task automatic apply(string req, logic wv = 1'b0, logic [2:0] wc = 3'd0,
                         logic [DW-1:0] wd = '0);
        item_t it;
        @(negedge clk);
        slot_valid = st_valid;
        slot_inv = st_inv;
        for (int i = 0; i < NS; i++) slot_code[i*3 +: 3] = st_code[i];
        wb_valid = wv;
        wb_code = wc;
        wb_data = wd;
        for (int i = 0; i < NS; i++) it.exp[i] = exp_slot(st_valid[i], st_code[i], st_inv[i]);
        it.req = req;
        sb_q.push_back(it);
        if (rst_n && wv && wc >= 3'd1 && wc <= 3'd5) mdl[int'(wc) - 1] = (wd != '0);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (slot_en !== it.exp) begin
                    errors++;
                    $display("FAIL %s: slot_en actual %b expected %b", it.req, slot_en, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) mdl[i] = 1'b0;
        clear_stage();

        // R1: reset state, registers read false; write-back during reset ignored
        set_slot(0, 1, 3'd0, 0);
        for (int i = 1; i <= 5; i++) set_slot(i, 1, 3'(i), 0);
        set_slot(6, 1, 3'd1, 1);
        set_slot(7, 0, 3'd0, 0);
        apply("R1", 1'b1, 3'd2, 32'h1);
        apply("R1");
        @(negedge clk); rst_n = 1'b1;
        for (int i = 1; i <= 5; i++) set_slot(i, 1, 3'(i), 1);
        apply("R1");

        // R3: invalid slots never enabled
        clear_stage();
        for (int i = 0; i < NS; i++) set_slot(i, 0, 3'(i % 6), 1'(i % 2));
        apply("R3");

        // R2: unconditional
        clear_stage();
        for (int i = 0; i < NS; i++) set_slot(i, 1, 3'd0, 0);
        apply("R2");

        // R5: reserved encodings squashed
        clear_stage();
        set_slot(0, 1, 3'd6, 0); set_slot(1, 1, 3'd6, 1);
        set_slot(2, 1, 3'd7, 0); set_slot(3, 1, 3'd7, 1);
        set_slot(4, 1, 3'd0, 1); set_slot(5, 1, 3'd0, 1);
        set_slot(6, 1, 3'd7, 1); set_slot(7, 1, 3'd6, 0);
        apply("R5");

        // R10 then R6: write B1 nonzero, same-cycle read sees old value
        clear_stage();
        set_slot(0, 1, 3'd2, 0); set_slot(1, 1, 3'd2, 1);
        apply("R10", 1'b1, 3'd2, 32'h0000_0100);
        apply("R6");

        // R2 stays enabled with registers set
        set_slot(2, 1, 3'd0, 0);
        apply("R2");

        // R4: distinct pattern across all five registers
        apply("R6", 1'b1, 3'd4, 32'h8000_0000);   // A1 true
        apply("R6", 1'b1, 3'd5, 32'h0);           // A2 false
        apply("R6", 1'b1, 3'd1, 32'h0);           // B0 false
        apply("R6", 1'b1, 3'd3, 32'h1);           // B2 true
        clear_stage();
        for (int i = 1; i <= 5; i++) set_slot(i - 1, 1, 3'(i), 0);
        for (int i = 1; i <= 3; i++) set_slot(i + 4, 1, 3'(i), 1);
        apply("R4");

        // R7: write-backs to non-register codes change nothing
        apply("R7", 1'b1, 3'd6, 32'hFFFF_FFFF);
        apply("R7", 1'b1, 3'd7, 32'h0);
        apply("R7", 1'b1, 3'd0, 32'h0);
        clear_stage();
        for (int i = 1; i <= 5; i++) set_slot(i - 1, 1, 3'(i), 1);
        set_slot(5, 1, 3'd4, 0); set_slot(6, 1, 3'd5, 0); set_slot(7, 1, 3'd2, 0);
        apply("R7");

        // R8: true and inverted on the same register in one packet
        clear_stage();
        set_slot(0, 1, 3'd2, 0); set_slot(1, 1, 3'd2, 1);
        set_slot(2, 1, 3'd5, 0); set_slot(3, 1, 3'd5, 1);
        set_slot(4, 1, 3'd4, 1); set_slot(5, 1, 3'd4, 0);
        set_slot(6, 1, 3'd1, 1); set_slot(7, 1, 3'd1, 0);
        apply("R8");

        // R6: clearing B1 with zero data; R10 same-cycle read
        apply("R10", 1'b1, 3'd2, 32'h0);
        apply("R6");

        // R9: enables follow inputs cycle by cycle
        clear_stage();
        set_slot(0, 1, 3'd4, 0); set_slot(3, 1, 3'd3, 0);
        apply("R9");
        clear_stage();
        set_slot(1, 1, 3'd4, 1); set_slot(3, 1, 3'd3, 1); set_slot(7, 1, 3'd0, 0);
        apply("R9");
        clear_stage();
        apply("R9");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule